// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block sequences a multi-channel analog-to-digital converter core across a range of input channels. Software picks a first and a last channel index, a scan style (single pass or endlessly repeating) and a trigger source. A conversion pass then begins in one of two ways. With the software source, writing the start bit together with the enable bit launches it. With a hardware source, writing the start bit only arms the block, and a later rising edge on the external trigger or on the timer-underflow line launches the pass.

Towards the converter core the block uses a plain handshake. It raises a one-cycle launch pulse along with a channel index, then waits for a one-cycle completion pulse before it moves to the next channel. Software sees a 16-bit control word. That word carries the enable and start bits it wrote, a busy flag, and a 3-bit field naming the channel in conversion. Once activity stops, the field names the channel converted last, except that it wraps to 0 after channel 7.

Clearing the start bit asks the block to stop, but the conversion already in flight is allowed to finish first. The start bit is never cleared by the hardware. Clearing the enable bit halts the sequencer at once.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the control word reads 16'h0000 and no launch pulse is issued.
- R2: Control word layout: bits 14:12 channel status (value k means channel k), bit 10 busy, bit 1 start, bit 0 enable; bits 15, 11 and 9:2 read 0; a write stores ctl_wdata[1] into start and ctl_wdata[0] into enable.
- R3: With trigger source 2'b00 (software), a write that sets start from 0 to 1 with enable 1 raises conv_start on the second cycle after the write cycle, with conv_chan equal to the first channel and busy 1.
- R4: Channels are converted in ascending order from first to last, one launch per completion; while busy the status field equals the channel of the latest launch and does not change between completions.
- R5: Single-pass mode (cfg_cont 0): after the completion of the last channel, busy drops to 0, no further launch follows, and the status holds the last channel, or 0 when that channel is 7.
- R6: Repeating mode (cfg_cont 1): after the last channel the scan restarts at the first channel for as long as start stays 1.
- R7: Writing start to 0 lets the conversion in flight finish; then busy drops to 0, no further launch follows, and the status holds the last converted channel, or 0 when it is 7.
- R8: Start is never cleared by the hardware; writing 1 to start while it is already 1 launches nothing.
- R9: With source 2'b01 (external) or 2'b10 (timer underflow), a rising edge of the selected input while idle, enabled and started launches one full scan; edges on the unselected input, edges while start is 0, and edges while busy launch nothing; writing start only arms the block.
- R10: While enable is 0 the block launches nothing and busy reads 0; clearing enable in the middle of a scan halts it within one cycle.
- R11: When the first index is greater than the last index, a scan converts only the first channel.
- R12: conv_start lasts exactly one cycle, and at most one conversion is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 2 | Written start (bit 1) and enable (bit 0) |
| ctl_rdata | output | 16 | Control word read value |
| cfg_first | input | 3 | First channel of a scan |
| cfg_last | input | 3 | Last channel of a scan |
| cfg_cont | input | 1 | 1 repeating scan, 0 single pass |
| cfg_src | input | 2 | Trigger source: 00 software, 01 external, 10 timer, 11 none |
| ext_trig | input | 1 | External trigger, rising edge |
| tmr_uflow | input | 1 | Timer underflow trigger, rising edge |
| conv_start | output | 1 | One-cycle launch pulse to the converter core |
| conv_chan | output | 3 | Channel index for the launched conversion |
| conv_done | input | 1 | One-cycle completion pulse from the converter core |

## Verification
On every cycle the assertions check that the launch pulse is one cycle wide and only appears while busy, that the status field matches the launched channel and holds still between completions, that a halted or disabled sequencer stays idle, and that a finished scan never parks the status at channel 7. The order of the channels, the restart in repeating mode, the rule that lets the in-flight conversion finish, trigger-source selection, ignored triggers and the reversed-range case all need whole sequences of events, so only the bench scenarios can show them. In those scenarios the bench compares the logged channel sequence and the parked status with values it computes on its own.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int CH_W  = 3;
  localparam int CTL_W = 16;
  localparam logic [CH_W-1:0] CH_MAX = '1;
  localparam logic [CH_W-1:0] CH_ONE = {{(CH_W-1){1'b0}}, 1'b1};

  typedef enum logic [1:0] {
    SRC_SW   = 2'b00,
    SRC_EXT  = 2'b01,
    SRC_TMR  = 2'b10,
    SRC_NONE = 2'b11
  } src_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } st_e;

  // channel that closes a pass; a reversed range closes on the first channel
  function automatic logic [CH_W-1:0] pass_end(input logic [CH_W-1:0] first,
                                               input logic [CH_W-1:0] last);
    return (first > last) ? first : last;
  endfunction

  function automatic logic [CH_W-1:0] step_chan(input logic [CH_W-1:0] ch);
    return ch + CH_ONE;
  endfunction

  // value the status field keeps once the sequencer stops
  function automatic logic [CH_W-1:0] park_status(input logic [CH_W-1:0] ch);
    return (ch == CH_MAX) ? '0 : ch;
  endfunction

  function automatic logic [CTL_W-1:0] pack_ctl(input logic [CH_W-1:0] stat,
                                                input logic busy,
                                                input logic run,
                                                input logic en);
    logic [CTL_W-1:0] w;
    w        = '0;
    w[14:12] = stat;
    w[10]    = busy;
    w[1]     = run;
    w[0]     = en;
    return w;
  endfunction
endpackage

// File: rtl/adc_scan_ctlreg.sv
module adc_scan_ctlreg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] wdata,
  output logic       en_q,
  output logic       run_q,
  output logic       sw_go_q
);
  logic sw_rise;

  // a software launch needs start rising and enable set by the same write
  assign sw_rise = wr && wdata[1] && wdata[0] && !run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      run_q   <= 1'b0;
      sw_go_q <= 1'b0;
    end else begin
      sw_go_q <= sw_rise;
      if (wr) begin
        run_q <= wdata[1];
        en_q  <= wdata[0];
      end
    end
  end
endmodule

// File: rtl/adc_scan_trig.sv
module adc_scan_trig
  import adc_scan_pkg::*;
#(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] trig_in,
  input  logic [1:0]       src,
  output logic             hw_go
);
  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] rise;

  for (genvar i = 0; i < N_SRC; i++) begin : g_edge
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= trig_in[i];
    end
    assign rise[i] = trig_in[i] && !prev_q[i];
  end

  always_comb begin
    case (src_e'(src))
      SRC_EXT: hw_go = rise[0];
      SRC_TMR: hw_go = rise[1];
      default: hw_go = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            run,
  input  logic            cont,
  input  logic [CH_W-1:0] first,
  input  logic [CH_W-1:0] last,
  input  logic [1:0]      src,
  input  logic            sw_go,
  input  logic            hw_go,
  input  logic            conv_done,
  output logic            conv_start,
  output logic [CH_W-1:0] conv_chan,
  output logic            busy,
  output logic [CH_W-1:0] status,
  output logic            scan_launch,
  output logic            scan_finish
);
  st_e             st;
  logic [CH_W-1:0] chan;
  logic [CH_W-1:0] stat;
  logic [CH_W-1:0] nxt;
  logic            start_q;
  logic            go;
  logic            done_ok;
  logic            at_end;
  logic            step_next;

  assign go        = (st == ST_IDLE) &&
                     ((src_e'(src) == SRC_SW) ? sw_go : (hw_go && run));
  assign done_ok   = (st == ST_CONV) && conv_done && !start_q;
  assign at_end    = (chan == pass_end(first, last));
  assign step_next = done_ok && run && (!at_end || cont);
  assign nxt       = (go || at_end) ? first : step_chan(chan);

  assign scan_launch = en && (go || step_next);
  assign scan_finish = en && done_ok && !step_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      chan    <= '0;
      stat    <= '0;
      start_q <= 1'b0;
    end else if (!en) begin
      st      <= ST_IDLE;
      start_q <= 1'b0;
    end else begin
      start_q <= scan_launch;
      if (scan_launch) begin
        st   <= ST_CONV;
        chan <= nxt;
        stat <= nxt;
      end else if (scan_finish) begin
        st   <= ST_IDLE;
        stat <= park_status(chan);
      end
    end
  end

  assign conv_start = start_q;
  assign conv_chan  = chan;
  assign busy       = (st == ST_CONV);
  assign status     = stat;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [1:0]       ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic [CH_W-1:0]  cfg_first,
  input  logic [CH_W-1:0]  cfg_last,
  input  logic             cfg_cont,
  input  logic [1:0]       cfg_src,
  input  logic             ext_trig,
  input  logic             tmr_uflow,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_chan,
  input  logic             conv_done
);
  logic            en_q;
  logic            run_q;
  logic            sw_go;
  logic            hw_go;
  logic            busy;
  logic [CH_W-1:0] status;
  logic            scan_launch;
  logic            scan_finish;

  adc_scan_ctlreg u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (ctl_wr),
    .wdata   (ctl_wdata),
    .en_q    (en_q),
    .run_q   (run_q),
    .sw_go_q (sw_go)
  );

  adc_scan_trig #(.N_SRC(2)) u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_in ({tmr_uflow, ext_trig}),
    .src     (cfg_src),
    .hw_go   (hw_go)
  );

  adc_scan_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en_q),
    .run         (run_q),
    .cont        (cfg_cont),
    .first       (cfg_first),
    .last        (cfg_last),
    .src         (cfg_src),
    .sw_go       (sw_go),
    .hw_go       (hw_go),
    .conv_done   (conv_done),
    .conv_start  (conv_start),
    .conv_chan   (conv_chan),
    .busy        (busy),
    .status      (status),
    .scan_launch (scan_launch),
    .scan_finish (scan_finish)
  );

  assign ctl_rdata = pack_ctl(status, busy, run_q, en_q);
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk
  import adc_scan_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            conv_start,
  input logic            conv_done,
  input logic [CH_W-1:0] conv_chan,
  input logic            busy,
  input logic [CH_W-1:0] status,
  input logic            en,
  input logic            scan_finish
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R12

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy); // R3

  AST_STATUS_IS_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (status == conv_chan)); // R4

  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> $stable(status)); // R4

  AST_OFF_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> (!busy && !conv_start)); // R10

  AST_FINISH_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    scan_finish |=> (!busy && (status != CH_MAX))); // R5
endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .conv_start  (conv_start),
  .conv_done   (conv_done),
  .conv_chan   (conv_chan),
  .busy        (busy),
  .status      (status),
  .en          (en_q),
  .scan_finish (scan_finish)
);

// File: tb/adc_scan_seq_test.sv
`timescale 1ns/1ps
module adc_scan_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [1:0]  ctl_wdata = 2'b00;
  logic [15:0] ctl_rdata;
  logic [2:0]  cfg_first = 3'd0;
  logic [2:0]  cfg_last = 3'd0;
  logic        cfg_cont = 1'b0;
  logic [1:0]  cfg_src = 2'b00;
  logic        ext_trig = 1'b0;
  logic        tmr_uflow = 1'b0;
  logic        conv_start;
  logic [2:0]  conv_chan;
  logic        conv_done = 1'b0;

  int checks = 0;
  int failures = 0;
  int log_ch [0:1023];
  int log_n = 0;
  int pend = 0;
  int lat = 0;

  always #2.5 clk = ~clk;

  adc_scan_seq uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .cfg_first(cfg_first), .cfg_last(cfg_last),
    .cfg_cont(cfg_cont), .cfg_src(cfg_src), .ext_trig(ext_trig),
    .tmr_uflow(tmr_uflow), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done)
  );

  // converter core model: logs each launch, answers after 1..3 cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      conv_done = 1'b0;
      pend = 0;
    end else begin
      conv_done = 1'b0;
      if (conv_start) begin
        pend = 1;
        lat = 1 + int'($urandom % 3);
        if (log_n < 1024) log_ch[log_n] = int'(conv_chan);
        log_n++;
      end else if (pend != 0) begin
        lat--;
        if (lat == 0) begin
          conv_done = 1'b1;
          pend = 0;
        end
      end
    end
  end

  function automatic int exp_len(input int f, input int l);
    return (f > l) ? 1 : (l - f + 1);
  endfunction

  function automatic int exp_park(input int ch);
    return (ch == 7) ? 0 : ch;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [1:0] v);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle(input string req);
    int quiet = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!ctl_rdata[10] && pend == 0 && !conv_done && !conv_start) quiet++;
      else quiet = 0;
      if (quiet >= 4) return;
    end
    chk({req, " idle timeout"}, 1, 0);
  endtask

  task automatic pulse(input bit on_ext);
    @(negedge clk);
    if (on_ext) ext_trig = 1'b1; else tmr_uflow = 1'b1;
    @(negedge clk);
    ext_trig = 1'b0;
    tmr_uflow = 1'b0;
  endtask

  task automatic check_scan(input string req, input int base, input int f, input int l);
    chk({req, " count"}, log_n - base, exp_len(f, l));
    for (int i = 0; i < exp_len(f, l); i++)
      if (base + i < log_n) chk({req, " chan"}, log_ch[base + i], f + i);
    chk({req, " parked status"}, int'(ctl_rdata[14:12]), exp_park((f > l) ? f : l));
    chk({req, " busy clear"}, int'(ctl_rdata[10]), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    int cnt;
    int f;
    int l;
    int seed;
    seed = int'($urandom(1234));
    idle_cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctl word", int'(ctl_rdata), 0);
    chk("R1 no launch", int'(conv_start), 0);

    // R2: layout, enable only
    wr_ctl(2'b01);
    chk("R2 read after enable", int'(ctl_rdata), 16'h0001);

    // R3 R4 R5: directed single pass 2..5
    cfg_first = 3'd2; cfg_last = 3'd5; cfg_cont = 1'b0; cfg_src = 2'b00;
    base = log_n;
    wr_ctl(2'b11);
    chk("R3 not yet", int'(conv_start), 0);
    @(negedge clk);
    chk("R3 launch", int'(conv_start), 1);
    chk("R3 chan", int'(conv_chan), 2);
    chk("R3 busy", int'(ctl_rdata[10]), 1);
    chk("R4 status", int'(ctl_rdata[14:12]), 2);
    wait_idle("R5");
    check_scan("R5 pass 2..5", base, 2, 5);
    chk("R2 reserved zero", int'(ctl_rdata & 16'h8BFC), 0);
    chk("R8 start kept", int'(ctl_rdata[1:0]), 3);
    cnt = log_n;
    idle_cycles(20);
    chk("R5 no relaunch", log_n, cnt);

    // R8: writing 1 again does nothing; 0 then 1 restarts
    wr_ctl(2'b11);
    idle_cycles(10);
    chk("R8 rewrite one", log_n, cnt);
    base = log_n;
    wr_ctl(2'b01);
    wr_ctl(2'b11);
    wait_idle("R8");
    check_scan("R8 restart", base, 2, 5);

    // R5: pass ends on channel 7
    cfg_first = 3'd5; cfg_last = 3'd7;
    base = log_n;
    wr_ctl(2'b01); wr_ctl(2'b11);
    wait_idle("R5 top");
    check_scan("R5 top channel", base, 5, 7);

    // R11: reversed range
    cfg_first = 3'd6; cfg_last = 3'd3;
    base = log_n;
    wr_ctl(2'b01); wr_ctl(2'b11);
    wait_idle("R11");
    check_scan("R11 reversed", base, 6, 3);

    // R6 R7: repeating 1..3 then stop
    cfg_first = 3'd1; cfg_last = 3'd3; cfg_cont = 1'b1;
    base = log_n;
    wr_ctl(2'b01); wr_ctl(2'b11);
    while (log_n - base < 8) @(negedge clk);
    wr_ctl(2'b01);
    wait_idle("R7");
    cnt = log_n - base;
    for (int i = 0; i < cnt; i++) chk("R6 repeat order", log_ch[base + i], 1 + (i % 3));
    chk("R7 parked last", int'(ctl_rdata[14:12]), exp_park(log_ch[log_n - 1]));
    chk("R7 busy clear", int'(ctl_rdata[10]), 0);
    cnt = log_n;
    idle_cycles(20);
    chk("R7 no launch after stop", log_n, cnt);

    // R7: stop in repeating 7..7 parks at 0
    cfg_first = 3'd7; cfg_last = 3'd7;
    base = log_n;
    wr_ctl(2'b11);
    while (log_n - base < 3) @(negedge clk);
    wr_ctl(2'b01);
    wait_idle("R7 top");
    chk("R7 top parks zero", int'(ctl_rdata[14:12]), 0);
    cfg_cont = 1'b0;

    // R9: hardware triggers
    cfg_first = 3'd0; cfg_last = 3'd2; cfg_src = 2'b01;
    cnt = log_n;
    pulse(1'b1);
    idle_cycles(8);
    chk("R9 edge while stopped", log_n, cnt);
    wr_ctl(2'b11);
    idle_cycles(8);
    chk("R9 write only arms", log_n, cnt);
    pulse(1'b0);
    idle_cycles(8);
    chk("R9 unselected source", log_n, cnt);
    base = log_n;
    pulse(1'b1);
    idle_cycles(2);
    chk("R9 busy after edge", int'(ctl_rdata[10]), 1);
    pulse(1'b1);
    wait_idle("R9 ext");
    check_scan("R9 external scan", base, 0, 2);
    cfg_src = 2'b10;
    base = log_n;
    pulse(1'b0);
    wait_idle("R9 tmr");
    check_scan("R9 timer scan", base, 0, 2);
    cfg_src = 2'b11;
    cnt = log_n;
    pulse(1'b1); pulse(1'b0);
    idle_cycles(8);
    chk("R9 no source", log_n, cnt);

    // R10: disabled block ignores everything
    cfg_src = 2'b00;
    wr_ctl(2'b00);
    cnt = log_n;
    wr_ctl(2'b10);
    idle_cycles(8);
    chk("R10 sw start disabled", log_n, cnt);
    cfg_src = 2'b01;
    pulse(1'b1);
    idle_cycles(8);
    chk("R10 ext disabled", log_n, cnt);
    chk("R10 busy zero", int'(ctl_rdata[10]), 0);

    // R10: disable in the middle of a scan
    cfg_src = 2'b00; cfg_first = 3'd0; cfg_last = 3'd7;
    wr_ctl(2'b00);
    base = log_n;
    wr_ctl(2'b11);
    while (log_n - base < 3) @(negedge clk);
    wr_ctl(2'b10);
    idle_cycles(1);
    chk("R10 halted busy", int'(ctl_rdata[10]), 0);
    cnt = log_n;
    idle_cycles(30);
    chk("R10 halted launches", log_n, cnt);
    chk("R10 bits kept", int'(ctl_rdata[1:0]), 2);
    wait_idle("R10");

    // random single passes
    wr_ctl(2'b01);
    for (int it = 0; it < 30; it++) begin
      f = int'($urandom % 8);
      l = int'($urandom % 8);
      cfg_first = 3'(f); cfg_last = 3'(l);
      base = log_n;
      wr_ctl(2'b01); wr_ctl(2'b11);
      wait_idle("R4 random");
      check_scan("R4 R11 random pass", base, f, l);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule